// File: doc/BRIEF.md
# Dual-Channel PCM Serial Port

This block sits between two bit-serial voice links and the parallel logic of a chip. Each link carries 8-bit samples, most significant bit first, once per 125 µs frame, timed by an external bit clock and an 8 kHz frame sync. In every frame the block collects two bytes per channel, a far-end byte and a near-end byte. It hands them inward with a one-cycle strobe per channel. On the same bit slots it shifts out the two bytes that the internal logic supplies for that channel. The bit clock, the syncs and the serial inputs are brought into the system clock domain through a two-stage synchronizer. Edges of the bit clock are then detected there, so all state runs on `clk`. The system clock must be several times faster than the bit clock.

A 2-bit mode input chooses the pin map: split (each channel on its own pin set and its own sync), multiplexed (channel 1's byte directly follows channel 0's byte on the index-0 pins after sync 0), cross-connected (both channels timed by sync 0, with far-end outputs and near-end inputs used on both pin sets), or off. Every serial output has an enable. An output whose enable is low models high impedance and drives 0. The mode pin is loaded continuously while reset is held and again at every frame start seen on sync 0.

Each of the two slot timers is a state machine with the states IDLE, SLOT0 and SLOT1. The transitions are: START (a bit-clock rise with the sync high, from any state, to SLOT0 with bit 7); STEP (a rise inside a slot with bit above 0, bit minus one); CHAIN (a rise at bit 0 of SLOT0 in multiplexed mode, to SLOT1 with bit 7); END (a rise at bit 0 of the last slot, to IDLE); and HALT (the timer is disabled, to IDLE). The timer for channel 0 always runs. The second timer runs only in split mode and follows sync 1.

Top module: `pcm_dual_port`

## Requirements
- R1: While `rst_n` is low, every output enable is low and no strobe is raised, even if the bit clock and syncs toggle.
- R2: The mode input is loaded only at a frame start on sync 0. A change of the mode pin in the middle of a frame leaves that frame's pin map unchanged.
- R3: Serial data is MSB first. Inputs are taken at the falling bit-clock edge. Outputs and enables change only after a rising edge. An enable goes high at the rise where its sync is seen and drops at the rise that follows bit 0.
- R4: After the falling edge that takes bit 0 of a channel's slot, that channel's `rx_stb_o` bit pulses for one `clk` cycle with the far and near bytes valid. There is exactly one pulse per slot.
- R5: Mode 2'b00 (split): channel 0 uses the index-0 pins from sync 0, and channel 1 uses the index-1 pins from sync 1, each with its own independent timing.
- R6: Mode 2'b01 (multiplexed): the index-0 pins carry channel 0's byte in bit periods 0 to 7 and channel 1's byte in periods 8 to 15 after sync 0. The index-1 pins and sync 1 are ignored, and the index-1 outputs stay disabled.
- R7: Mode 2'b10 (cross-connected): both channels are timed by sync 0 in periods 0 to 7. Both near outputs stay disabled and both far outputs are driven. Each channel takes its near byte from its own near input. Far inputs are ignored and the far bytes read 0. Both channels strobe in the same cycle.
- R8: Mode 2'b11 (off): all outputs stay disabled and no strobe is raised.
- R9: A serial output whose enable is low drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Pin map select: 00 split, 01 multiplexed, 10 cross, 11 off |
| bclk_i | input | 1 | External serial bit clock |
| sync0_i | input | 1 | Frame sync for channel 0 (and for both channels in modes 01 and 10) |
| sync1_i | input | 1 | Frame sync for channel 1 in split mode |
| far_in_i | input | 2 | Serial far-end data inputs, index 0 and 1 |
| near_in_i | input | 2 | Serial near-end data inputs, index 0 and 1 |
| far_tx_i | input | 2x8 | Far-end byte to send, per channel |
| near_tx_i | input | 2x8 | Near-end byte to send, per channel |
| far_out_o | output | 2 | Serial far-end data outputs |
| far_oe_o | output | 2 | Enables for far_out_o (low means high impedance) |
| near_out_o | output | 2 | Serial near-end data outputs |
| near_oe_o | output | 2 | Enables for near_out_o (low means high impedance) |
| rx_stb_o | output | 2 | Per-channel byte-received pulse |
| far_rx_o | output | 2x8 | Received far-end byte, per channel |
| near_rx_o | output | 2x8 | Received near-end byte, per channel |

## Verification
The two byte completions, one per channel, can land on the same `clk` cycle. This happens in cross-connected mode, where both channels end on the fall of period 7, and in split mode when both syncs arrive in the same bit period. The bench runs a cross frame and a split frame with coincident syncs. A separate expected queue per channel lets two simultaneous strobes each be popped and compared against their own far and near bytes. The checker also requires the two strobes to be paired in cross mode and kept apart in multiplexed mode.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        PM_SPLIT = 2'b00,
        PM_MUX   = 2'b01,
        PM_CROSS = 2'b10,
        PM_OFF   = 2'b11
    } pcm_mode_e;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'b00,
        TS_SLOT0 = 2'b01,
        TS_SLOT1 = 2'b10
    } slot_state_e;

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic         rise_o,
    output logic         fall_o
);

    logic [STAGES-1:0][W-1:0] pipe_q;
    logic                     prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
            prev_q <= 1'b0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], raw_i};
            prev_q <= pipe_q[STAGES-1][0];
        end
    end

    // bit 0 of the bundle is the bit clock
    assign sync_o = pipe_q[STAGES-1];
    assign rise_o = sync_o[0] & ~prev_q;
    assign fall_o = ~sync_o[0] & prev_q;

endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_i,
    input  logic                          rise_i,
    input  logic                          sync_i,
    input  logic                          two_slot_i,
    output slot_state_e                   state_o,
    output logic [$clog2(SAMPLE_W)-1:0]   bit_o,
    output logic                          start_o
);

    localparam int BW = $clog2(SAMPLE_W);
    localparam logic [BW-1:0] TOP_BIT = BW'(SAMPLE_W - 1);
    localparam logic [BW-1:0] ONE     = BW'(1);

    slot_state_e     state_q, state_d;
    logic [BW-1:0]   bit_q, bit_d;

    // next state
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        if (!en_i) begin                         // HALT
            state_d = TS_IDLE;
            bit_d   = TOP_BIT;
        end else if (rise_i && sync_i) begin     // START
            state_d = TS_SLOT0;
            bit_d   = TOP_BIT;
        end else if (rise_i) begin
            unique case (state_q)
                TS_IDLE: begin
                    state_d = TS_IDLE;
                end
                TS_SLOT0: begin
                    if (bit_q == '0) begin
                        state_d = two_slot_i ? TS_SLOT1 : TS_IDLE;  // CHAIN / END
                        bit_d   = TOP_BIT;
                    end else begin
                        bit_d   = bit_q - ONE;                      // STEP
                    end
                end
                TS_SLOT1: begin
                    if (bit_q == '0) begin
                        state_d = TS_IDLE;                          // END
                        bit_d   = TOP_BIT;
                    end else begin
                        bit_d   = bit_q - ONE;                      // STEP
                    end
                end
                default: begin
                    state_d = TS_IDLE;
                    bit_d   = TOP_BIT;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            bit_q   <= TOP_BIT;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        bit_o   = bit_q;
        start_o = en_i & rise_i & sync_i;
    end

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_i,
    input  logic                last_i,
    input  logic                far_bit_i,
    input  logic                near_bit_i,
    output logic                stb_o,
    output logic [SAMPLE_W-1:0] far_byte_o,
    output logic [SAMPLE_W-1:0] near_byte_o
);

    logic [SAMPLE_W-1:0] far_sh_q, near_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            far_sh_q    <= '0;
            near_sh_q   <= '0;
            far_byte_o  <= '0;
            near_byte_o <= '0;
            stb_o       <= 1'b0;
        end else begin
            stb_o <= cap_i & last_i;
            if (cap_i) begin
                far_sh_q  <= {far_sh_q[SAMPLE_W-2:0], far_bit_i};
                near_sh_q <= {near_sh_q[SAMPLE_W-2:0], near_bit_i};
            end
            if (cap_i && last_i) begin
                far_byte_o  <= {far_sh_q[SAMPLE_W-2:0], far_bit_i};
                near_byte_o <= {near_sh_q[SAMPLE_W-2:0], near_bit_i};
            end
        end
    end

endmodule

// File: rtl/pcm_dual_port.sv
module pcm_dual_port
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_i,
    input  logic                     bclk_i,
    input  logic                     sync0_i,
    input  logic                     sync1_i,
    input  logic [1:0]               far_in_i,
    input  logic [1:0]               near_in_i,
    input  logic [1:0][SAMPLE_W-1:0] far_tx_i,
    input  logic [1:0][SAMPLE_W-1:0] near_tx_i,
    output logic [1:0]               far_out_o,
    output logic [1:0]               far_oe_o,
    output logic [1:0]               near_out_o,
    output logic [1:0]               near_oe_o,
    output logic [1:0]               rx_stb_o,
    output logic [1:0][SAMPLE_W-1:0] far_rx_o,
    output logic [1:0][SAMPLE_W-1:0] near_rx_o
);

    localparam int BW    = $clog2(SAMPLE_W);
    localparam int RAW_W = 3 + 2 * NUM_LANES;

    // ---- input synchronisation and bit-clock edges
    logic [RAW_W-1:0] raw_bus, syn_bus;
    logic             bclk_rise, bclk_fall;
    logic             sync0_s, sync1_s;
    logic [1:0]       far_s, near_s;

    assign raw_bus = {near_in_i, far_in_i, sync1_i, sync0_i, bclk_i};

    pcm_edge_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_bus),
        .sync_o (syn_bus),
        .rise_o (bclk_rise),
        .fall_o (bclk_fall)
    );

    assign sync0_s = syn_bus[1];
    assign sync1_s = syn_bus[2];
    assign far_s   = syn_bus[4:3];
    assign near_s  = syn_bus[6:5];

    // ---- mode register: follows the pin in reset, reloads at sync-0 frame start
    pcm_mode_e   mode_q;
    logic        start0, start1;
    slot_state_e st0, st1;
    logic [BW-1:0] bit0, bit1;

    always_ff @(posedge clk) begin
        if (!rst_n || start0) begin
            mode_q <= pcm_mode_e'(mode_i);
        end
    end

    // ---- slot timers
    pcm_slot_timer #(.SAMPLE_W(SAMPLE_W)) u_tmr0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (1'b1),
        .rise_i     (bclk_rise),
        .sync_i     (sync0_s),
        .two_slot_i (mode_q == PM_MUX),
        .state_o    (st0),
        .bit_o      (bit0),
        .start_o    (start0)
    );

    pcm_slot_timer #(.SAMPLE_W(SAMPLE_W)) u_tmr1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (mode_q == PM_SPLIT),
        .rise_i     (bclk_rise),
        .sync_i     (sync1_s),
        .two_slot_i (1'b0),
        .state_o    (st1),
        .bit_o      (bit1),
        .start_o    (start1)
    );

    // ---- lane map: which timer, slot and pins serve each channel
    logic [1:0]          lane_act;
    logic [1:0][BW-1:0]  lane_bit;
    logic [1:0]          lane_far, lane_near;

    always_comb begin
        lane_act[0]  = (mode_q != PM_OFF) && (st0 == TS_SLOT0);
        lane_bit[0]  = bit0;
        lane_far[0]  = (mode_q == PM_CROSS) ? 1'b0 : far_s[0];
        lane_near[0] = near_s[0];
        unique case (mode_q)
            PM_SPLIT: begin
                lane_act[1]  = (st1 == TS_SLOT0);
                lane_bit[1]  = bit1;
                lane_far[1]  = far_s[1];
                lane_near[1] = near_s[1];
            end
            PM_MUX: begin
                lane_act[1]  = (st0 == TS_SLOT1);
                lane_bit[1]  = bit0;
                lane_far[1]  = far_s[0];
                lane_near[1] = near_s[0];
            end
            PM_CROSS: begin
                lane_act[1]  = (st0 == TS_SLOT0);
                lane_bit[1]  = bit0;
                lane_far[1]  = 1'b0;
                lane_near[1] = near_s[1];
            end
            default: begin
                lane_act[1]  = 1'b0;
                lane_bit[1]  = bit0;
                lane_far[1]  = 1'b0;
                lane_near[1] = 1'b0;
            end
        endcase
    end

    // ---- receive lanes
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        pcm_rx_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .cap_i       (lane_act[g] & bclk_fall),
            .last_i      (lane_bit[g] == '0),
            .far_bit_i   (lane_far[g]),
            .near_bit_i  (lane_near[g]),
            .stb_o       (rx_stb_o[g]),
            .far_byte_o  (far_rx_o[g]),
            .near_byte_o (near_rx_o[g])
        );
    end

    // ---- serial outputs and enables
    logic mux_mode, split_mode, cross_mode;
    logic far_bit0, near_bit0;

    assign mux_mode   = (mode_q == PM_MUX);
    assign split_mode = (mode_q == PM_SPLIT);
    assign cross_mode = (mode_q == PM_CROSS);

    always_comb begin
        far_oe_o[0]  = lane_act[0] | (mux_mode & lane_act[1]);
        near_oe_o[0] = (lane_act[0] & ~cross_mode) | (mux_mode & lane_act[1]);
        far_oe_o[1]  = lane_act[1] & (split_mode | cross_mode);
        near_oe_o[1] = lane_act[1] & split_mode;

        far_bit0  = lane_act[0] ? far_tx_i[0][lane_bit[0]]  : far_tx_i[1][lane_bit[1]];
        near_bit0 = lane_act[0] ? near_tx_i[0][lane_bit[0]] : near_tx_i[1][lane_bit[1]];

        far_out_o[0]  = far_oe_o[0]  & far_bit0;
        near_out_o[0] = near_oe_o[0] & near_bit0;
        far_out_o[1]  = far_oe_o[1]  & far_tx_i[1][lane_bit[1]];
        near_out_o[1] = near_oe_o[1] & near_tx_i[1][lane_bit[1]];
    end

endmodule

// File: rtl/pcm_dual_port_chk.sv
module pcm_dual_port_chk
    import pcm_port_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input pcm_mode_e  mode_q,
    input logic       bclk_rise,
    input logic       bclk_fall,
    input logic [1:0] far_oe_o,
    input logic [1:0] near_oe_o,
    input logic [1:0] rx_stb_o
);

    // R3
    oe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({far_oe_o, near_oe_o}) |-> $past(bclk_rise));

    // R4
    stb_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb_o != 2'b00) |-> $past(bclk_fall));

    // R4
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb_o != 2'b00) |=> (($past(rx_stb_o) & rx_stb_o) == 2'b00));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_OFF) |-> (far_oe_o == 2'b00 && near_oe_o == 2'b00 && rx_stb_o == 2'b00));

    // R6
    mux_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_MUX) |-> (rx_stb_o != 2'b11 && far_oe_o[1] == 1'b0 && near_oe_o[1] == 1'b0));

    // R7
    cross_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_CROSS) |-> (rx_stb_o[0] == rx_stb_o[1] && near_oe_o == 2'b00));

endmodule

bind pcm_dual_port pcm_dual_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .far_oe_o  (far_oe_o),
    .near_oe_o (near_oe_o),
    .rx_stb_o  (rx_stb_o)
);

// File: tb/pcm_dual_port_test.sv
`timescale 1ns/1ps
module pcm_dual_port_test;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       mode_pin;
    logic             bclk, sync0, sync1;
    logic [1:0]       far_in, near_in;
    logic [1:0][7:0]  far_tx, near_tx;
    logic [1:0]       far_out, far_oe, near_out, near_oe, rx_stb;
    logic [1:0][7:0]  far_rx, near_rx;

    always #2.5 clk = ~clk;

    pcm_dual_port uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_pin), .bclk_i(bclk),
        .sync0_i(sync0), .sync1_i(sync1), .far_in_i(far_in), .near_in_i(near_in),
        .far_tx_i(far_tx), .near_tx_i(near_tx), .far_out_o(far_out), .far_oe_o(far_oe),
        .near_out_o(near_out), .near_oe_o(near_oe), .rx_stb_o(rx_stb),
        .far_rx_o(far_rx), .near_rx_o(near_rx)
    );

    int errs = 0;
    int checks = 0;
    string cur_tag = "R1";
    logic [15:0] exp_q0[$];
    logic [15:0] exp_q1[$];

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // monitor: pops the expected bytes as each strobe appears (R4)
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (rx_stb[0]) begin
                if (exp_q0.size() == 0) check({cur_tag, " R4"}, "ch0 unexpected strobe", 1, 0);
                else check({cur_tag, " R4"}, "ch0 far/near bytes", {far_rx[0], near_rx[0]}, exp_q0.pop_front());
            end
            if (rx_stb[1]) begin
                if (exp_q1.size() == 0) check({cur_tag, " R4"}, "ch1 unexpected strobe", 1, 0);
                else check({cur_tag, " R4"}, "ch1 far/near bytes", {far_rx[1], near_rx[1]}, exp_q1.pop_front());
            end
        end
    end

    // one frame of 20 bit periods; m is the mode at frame start, m_late is put on the pin at period 4
    task automatic run_frame(input logic [1:0] m, input logic [1:0] m_late, input int sb,
                             input logic [15:0] fw0, input logic [15:0] nw0,
                             input logic [15:0] fw1, input logic [15:0] nw1, input string tag);
        int st;
        logic a0, in1, foe1, noe1;
        logic eb_f, eb_n;
        st = (m == 2'b00) ? sb : 0;
        cur_tag = tag;
        mode_pin = m;
        if (m != 2'b11) exp_q0.push_back({(m == 2'b10) ? 8'h00 : fw0[15:8], nw0[15:8]});
        case (m)
            2'b00: exp_q1.push_back({fw1[15:8], nw1[15:8]});
            2'b01: exp_q1.push_back({fw0[7:0], nw0[7:0]});
            2'b10: exp_q1.push_back({8'h00, nw1[15:8]});
            default: ;
        endcase
        for (int p = 0; p < 20; p++) begin
            @(negedge clk);
            if (p == 4) mode_pin = m_late;
            bclk  = 1'b1;
            sync0 = (p == 0);
            sync1 = (p == sb);
            far_in[0]  = (p < 16) ? fw0[15-p] : 1'b0;
            near_in[0] = (p < 16) ? nw0[15-p] : 1'b0;
            far_in[1]  = (p >= st && p - st < 16) ? fw1[15-(p-st)] : 1'b0;
            near_in[1] = (p >= st && p - st < 16) ? nw1[15-(p-st)] : 1'b0;
            repeat (7) @(negedge clk);
            // index-0 pins (R3 timing, R9 disabled value)
            a0 = (m != 2'b11) && (p < ((m == 2'b01) ? 16 : 8));
            eb_f = 1'b0; eb_n = 1'b0;
            if (a0) begin
                eb_f = (p < 8) ? far_tx[0][7-p]  : far_tx[1][15-p];
                eb_n = (p < 8) ? near_tx[0][7-p] : near_tx[1][15-p];
            end
            check({tag, " R3"}, $sformatf("far_oe0 p%0d", p), far_oe[0], a0);
            check({tag, " R3"}, $sformatf("near_oe0 p%0d", p), near_oe[0], a0 && m != 2'b10);
            check({tag, " R3 R9"}, $sformatf("far_out0 p%0d", p), far_out[0], eb_f);
            check({tag, " R3 R9"}, $sformatf("near_out0 p%0d", p), near_out[0], (m != 2'b10) ? eb_n : 1'b0);
            // index-1 pins
            in1  = (p >= st) && (p < st + 8);
            foe1 = in1 && (m == 2'b00 || m == 2'b10);
            noe1 = in1 && (m == 2'b00);
            check({tag, " R3"}, $sformatf("far_oe1 p%0d", p), far_oe[1], foe1);
            check({tag, " R3"}, $sformatf("near_oe1 p%0d", p), near_oe[1], noe1);
            check({tag, " R9"}, $sformatf("far_out1 p%0d", p), far_out[1], foe1 ? far_tx[1][7-(p-st)] : 1'b0);
            check({tag, " R9"}, $sformatf("near_out1 p%0d", p), near_out[1], noe1 ? near_tx[1][7-(p-st)] : 1'b0);
            @(negedge clk);
            bclk = 1'b0;
            repeat (7) @(negedge clk);
        end
        check({tag, " R4"}, "ch0 strobes outstanding", exp_q0.size(), 0);
        check({tag, " R4"}, "ch1 strobes outstanding", exp_q1.size(), 0);
        exp_q0.delete();
        exp_q1.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_pin = 2'b00; bclk = 1'b0; sync0 = 1'b0; sync1 = 1'b0;
        far_in = '0; near_in = '0;
        far_tx = {8'h3C, 8'hA5}; near_tx = {8'h81, 8'h5E};
        repeat (6) @(negedge clk);
        // R1: bit clock and sync toggling during reset must not enable anything
        bclk = 1'b1; sync0 = 1'b1; sync1 = 1'b1;
        repeat (8) @(negedge clk);
        check("R1", "far_oe in reset", far_oe, 0);
        check("R1", "near_oe in reset", near_oe, 0);
        check("R1", "rx_stb in reset", rx_stb, 0);
        bclk = 1'b0; sync0 = 1'b0; sync1 = 1'b0;
        repeat (8) @(negedge clk);
        check("R1", "far_oe after fall in reset", far_oe, 0);
        rst_n = 1'b1;
        repeat (16) @(negedge clk);
        check("R1", "outputs idle after reset", {far_oe, near_oe, rx_stb}, 0);

        run_frame(2'b00, 2'b00, 3, 16'hB6_00, 16'h4D_FF, 16'hE1_00, 16'h17_00, "R5");
        far_tx = {8'h96, 8'h0F}; near_tx = {8'hC3, 8'hF0};
        run_frame(2'b00, 2'b00, 0, 16'h59_00, 16'hA2_00, 16'h3E_00, 16'hC8_00, "R5");
        far_tx = {8'h12, 8'hED}; near_tx = {8'h7B, 8'h84};
        run_frame(2'b01, 2'b01, 2, 16'hD3_6A, 16'h2C_95, 16'hFF_FF, 16'hFF_FF, "R6");
        far_tx = {8'h6D, 8'hB2}; near_tx = {8'h49, 8'h1E};
        run_frame(2'b10, 2'b10, 0, 16'hFF_00, 16'h74_00, 16'hAA_00, 16'hE5_00, "R7");
        run_frame(2'b11, 2'b11, 1, 16'h9C_33, 16'h66_C9, 16'h5A_00, 16'hA5_00, "R8");
        far_tx = {8'h0E, 8'hD1}; near_tx = {8'hB8, 8'h27};
        run_frame(2'b00, 2'b01, 2, 16'h8E_71, 16'h35_CA, 16'h6B_00, 16'h94_00, "R2");
        run_frame(2'b01, 2'b00, 5, 16'h1F_E0, 16'hC7_38, 16'h00_00, 16'h00_00, "R2");
        run_frame(2'b10, 2'b11, 0, 16'h00_00, 16'hD9_00, 16'h00_00, 16'h2B_00, "R2");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule